// File: doc/BRIEF.md
# AHB Slave Protocol Compliance Monitor

This block is a synthesizable monitor that sits beside one AHB slave and watches the handshake between the bus and that slave every clock cycle. It samples the slave select, the incoming ready, the transfer type, the slave's own ready and its response. It follows a small protocol state machine to decide whether each answer from the slave is allowed for the transfer that is currently in its data phase.

The monitor sorts behaviour into three classes. Legal behaviour leaves both flags low. An answer the protocol forbids for a valid transfer sets the `violation` flag. An input sequence that the protocol never produces, such as a sequential transfer with no transfer in progress, sets the separate `dontCare` flag. That case is therefore never reported as a slave fault. Both flags stay set until a synchronous active-low reset. A slave is judged compliant when `violation` never rises.

Encodings used throughout: transfer type IDLE=2'b00, BUSY=2'b01, NSEQ=2'b10, SEQ=2'b11; response OKAY=2'b00, any other response value is non-OKAY.

Top module: `ahb_slave_monitor`

## Requirements
- R1: While `rstN` is low at a rising clock edge, the monitor returns to its no-transfer state and both `violation` and `dontCare` read 0 after that edge.
- R2: With no transfer pending, a cycle in which `selIn` or `readyIn` is low starts nothing and sets no flag, whatever the transfer type (SEQ=2'b11 included) and the slave response.
- R3: With no transfer pending, `selIn` and `readyIn` both high with NSEQ (2'b10) opens an active transfer, and IDLE (2'b00) or BUSY (2'b01) opens an idle/busy phase; neither sets a flag.
- R4: With no transfer pending, `selIn` and `readyIn` both high with SEQ (2'b11) sets `dontCare` after that edge and leaves `violation` at 0.
- R5: In an idle/busy phase, the slave must answer with `readyOut` high and response OKAY (2'b00) in that cycle; `readyOut` low or any non-OKAY response sets `violation` after that edge.
- R6: In an active transfer, or while it waits, `readyOut` low extends the wait with no flag, for any response value.
- R7: In an active transfer, or while it waits, `readyOut` high with a non-OKAY response sets `violation` after that edge.
- R8: When the slave completes with `readyOut` high and OKAY, `selIn` low returns the monitor to no transfer; `selIn` high follows the new transfer type: IDLE/BUSY to an idle/busy phase, NSEQ/SEQ to an active transfer.
- R9: Once set, `violation` and `dontCare` stay set until reset, whatever the inputs; the two flags are never high together.
- R10: When a forbidden completion and a new transfer request fall in the same cycle, the violation is recorded and the new request is not followed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| selIn | input | 1 | Slave select seen by the monitored slave |
| readyIn | input | 1 | Ready from the bus, high when the previous transfer on the bus has finished |
| transType | input | 2 | Transfer type: IDLE=00, BUSY=01, NSEQ=10, SEQ=11 |
| readyOut | input | 1 | Ready driven by the monitored slave |
| resp | input | 2 | Response driven by the monitored slave, OKAY=00 |
| violation | output | 1 | Sticky flag: the slave gave a forbidden answer |
| dontCare | output | 1 | Sticky flag: the input sequence lies outside the protocol |

## Verification
The completion check of the current data phase and the decode of the next address phase fall in the same cycle, because one edge both judges the slave's answer and picks the next state from the new transfer type. The bench provokes this overlap by holding select and a fresh NSEQ while the slave in an idle/busy phase answers with a non-OKAY response, and by ending a wait with an OKAY while select is dropped or kept with a new type. It judges the outcome at the flags and by the next vector: a correct follow is exposed by whether a later SEQ sets `dontCare` (only from no transfer) or a later low `readyOut` stays quiet (only from an active transfer).

// File: rtl/ahb_mon_pkg.sv
package ahb_mon_pkg;

  localparam int TRANS_W = 2;
  localparam int RESP_W  = 2;

  localparam logic [TRANS_W-1:0] TR_IDLE = 2'b00;
  localparam logic [TRANS_W-1:0] TR_BUSY = 2'b01;
  localparam logic [TRANS_W-1:0] TR_NSEQ = 2'b10;
  localparam logic [TRANS_W-1:0] TR_SEQ  = 2'b11;
  localparam logic [RESP_W-1:0]  RESP_OKAY = '0;

  typedef enum logic [2:0] {
    ST_ORIG     = 3'd0,
    ST_IDLEBUSY = 3'd1,
    ST_XFER     = 3'd2,
    ST_WAIT     = 3'd3,
    ST_VIO      = 3'd4,
    ST_DC       = 3'd5
  } monState_t;

  // decoded bus events, datapath -> control
  typedef struct packed {
    logic granted;    // select and incoming ready both high
    logic selected;   // select high
    logic isIdleBusy; // IDLE or BUSY
    logic isNseq;
    logic isSeq;
    logic slaveReady; // slave ready high
    logic respOk;     // OKAY response
  } evStrobe_t;

  // strobes, control -> datapath
  typedef struct packed {
    logic markVio;
    logic markDc;
  } ctrlStrobe_t;

endpackage

// File: rtl/ahb_mon_datapath.sv
module ahb_mon_datapath
  import ahb_mon_pkg::*;
#(
  parameter int TRANS_WIDTH = TRANS_W,
  parameter int RESP_WIDTH  = RESP_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   selIn,
  input  logic                   readyIn,
  input  logic [TRANS_WIDTH-1:0] transType,
  input  logic                   readyOut,
  input  logic [RESP_WIDTH-1:0]  resp,
  input  ctrlStrobe_t            ctrl,
  output evStrobe_t              ev,
  output logic                   violation,
  output logic                   dontCare
);

  localparam logic [RESP_WIDTH-1:0] OKAY_CODE = RESP_WIDTH'(RESP_OKAY);

  logic vioFlag;
  logic dcFlag;

  always_comb begin
    ev            = '0;
    ev.granted    = selIn && readyIn;
    ev.selected   = selIn;
    ev.isIdleBusy = (transType == TR_IDLE) || (transType == TR_BUSY);
    ev.isNseq     = (transType == TR_NSEQ);
    ev.isSeq      = (transType == TR_SEQ);
    ev.slaveReady = readyOut;
    ev.respOk     = (resp == OKAY_CODE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vioFlag <= 1'b0;
      dcFlag  <= 1'b0;
    end else begin
      if (ctrl.markVio) vioFlag <= 1'b1;
      if (ctrl.markDc)  dcFlag  <= 1'b1;
    end
  end

  assign violation = vioFlag;
  assign dontCare  = dcFlag;

endmodule

// File: rtl/ahb_mon_control.sv
module ahb_mon_control
  import ahb_mon_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  evStrobe_t   ev,
  output ctrlStrobe_t ctrl,
  output monState_t   curState
);

  monState_t stateQ;
  monState_t stateD;
  monState_t followState;

  // next phase after a clean completion
  always_comb begin
    if (!ev.selected)       followState = ST_ORIG;
    else if (ev.isIdleBusy) followState = ST_IDLEBUSY;
    else                    followState = ST_XFER;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_ORIG: begin
        if (ev.granted) begin
          if (ev.isSeq)       stateD = ST_DC;
          else if (ev.isNseq) stateD = ST_XFER;
          else                stateD = ST_IDLEBUSY;
        end
      end
      ST_IDLEBUSY: begin
        if (ev.slaveReady && ev.respOk) stateD = followState;
        else                            stateD = ST_VIO;
      end
      ST_XFER, ST_WAIT: begin
        if (!ev.slaveReady)  stateD = ST_WAIT;
        else if (!ev.respOk) stateD = ST_VIO;
        else                 stateD = followState;
      end
      ST_VIO:  stateD = ST_VIO;
      ST_DC:   stateD = ST_DC;
      default: stateD = ST_ORIG;
    endcase
  end

  always_comb begin
    ctrl         = '0;
    ctrl.markVio = (stateD == ST_VIO) && (stateQ != ST_VIO);
    ctrl.markDc  = (stateD == ST_DC) && (stateQ != ST_DC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_ORIG;
    else       stateQ <= stateD;
  end

  assign curState = stateQ;

endmodule

// File: rtl/ahb_slave_monitor.sv
module ahb_slave_monitor
  import ahb_mon_pkg::*;
#(
  parameter int TRANS_WIDTH = TRANS_W,
  parameter int RESP_WIDTH  = RESP_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   selIn,
  input  logic                   readyIn,
  input  logic [TRANS_WIDTH-1:0] transType,
  input  logic                   readyOut,
  input  logic [RESP_WIDTH-1:0]  resp,
  output logic                   violation,
  output logic                   dontCare
);

  evStrobe_t   evBus;
  ctrlStrobe_t ctrlBus;
  monState_t   curState;

  ahb_mon_datapath #(
    .TRANS_WIDTH(TRANS_WIDTH),
    .RESP_WIDTH (RESP_WIDTH)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .selIn    (selIn),
    .readyIn  (readyIn),
    .transType(transType),
    .readyOut (readyOut),
    .resp     (resp),
    .ctrl     (ctrlBus),
    .ev       (evBus),
    .violation(violation),
    .dontCare (dontCare)
  );

  ahb_mon_control i_control (
    .clk     (clk),
    .rstN    (rstN),
    .ev      (evBus),
    .ctrl    (ctrlBus),
    .curState(curState)
  );

endmodule

// File: rtl/ahb_mon_checker.sv
module ahb_mon_checker
  import ahb_mon_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       selIn,
  input logic       readyIn,
  input logic [1:0] transType,
  input logic       readyOut,
  input logic [1:0] resp,
  input logic       violation,
  input logic       dontCare,
  input monState_t  curState
);

  logic inXfer;
  assign inXfer = (curState == ST_XFER) || (curState == ST_WAIT);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |=> (!violation && !dontCare && curState == ST_ORIG)); // R1

  AST_ORIG_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_ORIG && !(selIn && readyIn)) |=> (curState == ST_ORIG && !dontCare)); // R2

  AST_ORIG_NSEQ: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_ORIG && selIn && readyIn && transType == 2'b10) |=> curState == ST_XFER); // R3

  AST_SEQ_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_ORIG && selIn && readyIn && transType == 2'b11) |=> (dontCare && !violation)); // R4

  AST_IDLE_ANSWER: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLEBUSY && !(readyOut && resp == 2'b00)) |=> violation); // R5

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (inXfer && !readyOut) |=> (curState == ST_WAIT && !violation)); // R6

  AST_ERR_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (inXfer && readyOut && resp != 2'b00) |=> violation); // R7

  AST_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    ((inXfer || curState == ST_IDLEBUSY) && readyOut && resp == 2'b00 && !selIn)
    |=> curState == ST_ORIG); // R8

  AST_VIO_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> violation); // R9

  AST_DC_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    dontCare |=> dontCare); // R9

  AST_FLAGS_APART: assert property (@(posedge clk) disable iff (!rstN)
    !(violation && dontCare)); // R9

  AST_VIO_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(violation) |-> $past(curState == ST_IDLEBUSY || inXfer)); // R10

endmodule

bind ahb_slave_monitor ahb_mon_checker i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .selIn    (selIn),
  .readyIn  (readyIn),
  .transType(transType),
  .readyOut (readyOut),
  .resp     (resp),
  .violation(violation),
  .dontCare (dontCare),
  .curState (curState)
);

// File: tb/test_ahb_slave_monitor.sv
module test_ahb_slave_monitor;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       selIn = 1'b0;
  logic       readyIn = 1'b1;
  logic [1:0] transType = 2'b00;
  logic       readyOut = 1'b1;
  logic [1:0] resp = 2'b00;
  logic       violation;
  logic       dontCare;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ahb_slave_monitor i_ahb_slave_monitor (
    .clk      (clk),
    .rstN     (rstN),
    .selIn    (selIn),
    .readyIn  (readyIn),
    .transType(transType),
    .readyOut (readyOut),
    .resp     (resp),
    .violation(violation),
    .dontCare (dontCare)
  );

  // {reset before, sel, readyIn, trans[1:0], readyOut, resp[1:0], expVio, expDc}
  localparam int NVEC = 28;
  localparam logic [9:0] VEC [NVEC] = '{
    10'b1_0_1_10_1_00_0_0, // 0  R2 not selected
    10'b0_1_0_11_1_00_0_0, // 1  R2 readyIn low, SEQ ignored
    10'b0_1_1_10_1_00_0_0, // 2  R3 NSEQ opens transfer
    10'b0_1_1_11_0_00_0_0, // 3  R6 wait
    10'b0_1_0_11_0_10_0_0, // 4  R6 wait, non-OKAY while low
    10'b0_1_1_11_1_00_0_0, // 5  R8 follow SEQ
    10'b0_1_1_00_1_00_0_0, // 6  R8 follow IDLE
    10'b0_0_1_00_1_00_0_0, // 7  R8 deselect to orig
    10'b0_1_1_11_1_00_0_1, // 8  R4 SEQ from orig
    10'b1_1_1_01_1_00_0_0, // 9  R3 BUSY opens idle/busy
    10'b0_1_1_00_0_00_1_0, // 10 R5 low ready in idle/busy
    10'b0_1_1_10_1_00_1_0, // 11 R9 sticky
    10'b0_1_1_11_1_00_1_0, // 12 R9 no dc after vio
    10'b1_1_1_10_1_00_0_0, // 13 R3
    10'b0_1_1_10_1_01_1_0, // 14 R7 error completion
    10'b1_1_1_00_1_00_0_0, // 15 R3
    10'b0_0_1_00_1_10_1_0, // 16 R5 non-OKAY in idle/busy
    10'b1_1_1_10_1_00_0_0, // 17 R3
    10'b0_1_1_11_0_01_0_0, // 18 R6 low ready any resp
    10'b0_1_1_11_1_01_1_0, // 19 R7
    10'b1_1_1_01_1_00_0_0, // 20 R3
    10'b0_1_1_10_1_00_0_0, // 21 R8 idle/busy follows NSEQ
    10'b0_1_1_11_0_00_0_0, // 22 R6 proves active transfer
    10'b0_0_0_00_1_00_0_0, // 23 R8 deselect
    10'b0_1_1_11_1_00_0_1, // 24 R4 proves orig
    10'b0_1_1_10_1_11_0_1, // 25 R9 dc sticky, no vio
    10'b1_1_1_00_1_00_0_0, // 26 R3
    10'b0_1_1_10_1_01_1_0  // 27 R10 vio beats new NSEQ
  };

  task automatic check(input string req, input logic expVio, input logic expDc);
    total++;
    if (violation !== expVio || dontCare !== expDc) begin
      bad++;
      $display("FAIL %s: violation=%b dontCare=%b expected violation=%b dontCare=%b",
               req, violation, dontCare, expVio, expDc);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    selIn = 1'b0; readyIn = 1'b1; transType = 2'b00; readyOut = 1'b1; resp = 2'b00;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic drive(input logic s, input logic ri, input logic [1:0] t,
                       input logic ro, input logic [1:0] r);
    @(negedge clk);
    selIn = s; readyIn = ri; transType = t; readyOut = ro; resp = r;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    if (!finished) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    doReset();
    @(posedge clk); #1;
    check("R1 reset state", 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][9]) doReset();
      drive(VEC[i][8], VEC[i][7], VEC[i][6:5], VEC[i][4], VEC[i][3:2]);
      check($sformatf("vector %0d", i), VEC[i][1], VEC[i][0]);
    end

    // R1: reset clears a set violation
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk); #1;
    check("R1 clears violation", 1'b0, 1'b0);

    // R1: reset held while a SEQ request is presented keeps flags low
    @(negedge clk);
    selIn = 1'b1; readyIn = 1'b1; transType = 2'b11;
    @(posedge clk); #1;
    check("R1 reset dominates", 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R4 after reset release", 1'b0, 1'b1);

    // R1: reset clears dontCare
    @(negedge clk);
    rstN = 1'b0;
    selIn = 1'b0;
    @(posedge clk); #1;
    check("R1 clears dontCare", 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    // R6: long wait stays clean
    drive(1'b1, 1'b1, 2'b10, 1'b1, 2'b00);
    for (int k = 0; k < 5; k++) begin
      drive(1'b0, 1'b0, 2'b00, 1'b0, 2'b00);
      check("R6 long wait", 1'b0, 1'b0);
    end
    drive(1'b0, 1'b1, 2'b00, 1'b1, 2'b00);
    check("R8 wait ends to orig", 1'b0, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule